// File: doc/BRIEF.md
# Multi-Axis Sample Ring Buffer

This block keeps a history of three-axis samples in a circular store, so that a host can collect them in bursts instead of servicing each sample as it arrives. Each accepted sample writes one entry per enabled axis into a common pool of `DEPTH` entries. Disabled axes take no space, so the enabled ones share the whole pool. An input divider can thin the sample stream. The host pulls data one byte at a time. In wide mode each entry comes out as a high byte followed by a low byte. In narrow mode each entry comes out as a single byte holding its top eight bits.

The host sees how much data is waiting through a count register. This register is refreshed only when the host strobes a count access. An interrupt line reports that the fill level has passed half or three quarters of the pool. A sticky flag records that old data was overwritten. Any change to the enable bit, the axis selection or the byte mode empties the store.

Top module: `axis_sample_ring`

## Requirements
- R1: The pool holds `DEPTH` (192) axis entries. This is 64 three-axis samples, or 192 samples with a single axis enabled. A write that does not fit drops the oldest stored entries, one for each enabled axis, and the count never exceeds `DEPTH`.
- R2: Axis enable bit 0 selects X, bit 1 selects Y and bit 2 selects Z. Only enabled axes are stored. Readout is oldest sample first and, within a sample, follows X, Y, Z order with disabled axes skipped.
- R3: While `cfg_buf_en` is 0, incoming samples are not stored and the count stays 0.
- R4: `cfg_rate_sel` 0 keeps every sample, 1 keeps every 2nd and 2 or 3 keeps every 4th. The first sample after a flush is always kept. Changing this field does not flush the store.
- R5: With `cfg_byte_mode` = 0, each entry reads out as two bytes. The first is bits 10..8 in the low three bits, with bits 7..3 copies of bit 10. The second is bits 7..0.
- R6: With `cfg_byte_mode` = 1, each entry reads out as one byte equal to bits 10..3.
- R7: `irq` is 1 exactly when `cfg_irq_en` is 1 and the stored entry count is nonzero and at least `DEPTH`/2 (`cfg_irq_hi` = 0) or 3·`DEPTH`/4 (`cfg_irq_hi` = 1). It follows the fill level in the cycle after each write or pop.
- R8: `fill_cnt` takes the number of unread entries on a clock edge where `cnt_rd` is 1, and holds that value otherwise.
- R9: A dropping write sets `ovf`. `ovf` then stays set until a `cnt_rd` edge with no new drop clears it.
- R10: A change of `cfg_buf_en`, `cfg_axis_en` or `cfg_byte_mode` empties the store on the next edge. A sample arriving in that cycle is discarded.
- R11: When the store is empty, `rd_byte` is 0x00 and `rd_pop` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | New sample present on the axis inputs |
| smp_x | input | DW (11) | X axis value |
| smp_y | input | DW (11) | Y axis value |
| smp_z | input | DW (11) | Z axis value |
| cfg_buf_en | input | 1 | Store enable |
| cfg_axis_en | input | 3 | Axis enables: bit 0 X, bit 1 Y, bit 2 Z |
| cfg_byte_mode | input | 1 | 1 = one byte per entry, 0 = two bytes |
| cfg_rate_sel | input | 2 | Input divider select |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_irq_hi | input | 1 | 0 = half-full threshold, 1 = three-quarter threshold |
| rd_pop | input | 1 | Consume the byte currently on `rd_byte` |
| cnt_rd | input | 1 | Count access: snapshot the fill level, clear `ovf` |
| rd_byte | output | 8 | Next byte to be read |
| fill_cnt | output | CW (8) | Entry count captured at the last count access |
| irq | output | 1 | Fill-level interrupt |
| ovf | output | 1 | Sticky overwrite flag |

## Verification
A wrong pointer or byte-phase state shows up at `rd_byte` on the very next pop. The value comes out of order, with the wrong axis, or with the wrong half of an entry. A wrong fill level shows through `irq` one cycle after the write that crosses a threshold, and through `fill_cnt` on the next count access. The wrap and drop paths are exercised by filling past capacity and checking that the first byte read is the second-oldest sample.

// File: rtl/asr_pkg.sv
package asr_pkg;

   localparam int unsigned NAX = 3;

   typedef enum logic [1:0] {
      RATE_ALL   = 2'd0,
      RATE_HALF  = 2'd1,
      RATE_QUART = 2'd2,
      RATE_QALT  = 2'd3
   } rate_e;

   function automatic logic [1:0] axis_count(input logic [NAX-1:0] en);
      return {1'b0, en[0]} + {1'b0, en[1]} + {1'b0, en[2]};
   endfunction

endpackage

// File: rtl/asr_decim.sv
module asr_decim
   import asr_pkg::*;
#(
   parameter int unsigned PW = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       stb,
   input  logic [1:0] rate_sel,
   output logic       keep
);

   if (PW < 2) begin : g_bad_pw
      $error("asr_decim: PW must be at least 2");
   end

   logic [PW-1:0] ph_q;
   logic [PW-1:0] ph_max;

   always_comb begin
      case (rate_e'(rate_sel))
         RATE_ALL:  ph_max = '0;
         RATE_HALF: ph_max = PW'(1);
         default:   ph_max = PW'(3);
      endcase
   end

   assign keep = stb && !clr && (ph_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (clr) begin
         ph_q <= '0;
      end else if (stb) begin
         ph_q <= (ph_q >= ph_max) ? '0 : ph_q + PW'(1);
      end
   end

   // R4: with any divider above one, two kept samples never follow back to back
   p_decim_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (keep && rate_sel != 2'd0) |=> !keep);

endmodule

// File: rtl/asr_store.sv
module asr_store
   import asr_pkg::*;
#(
   parameter int unsigned DW        = 11,
   parameter int unsigned DEPTH     = 192,
   parameter int unsigned AW        = 8,
   parameter bit          MEM_RESET = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NAX-1:0]           we,
   input  logic [NAX-1:0][AW-1:0]   waddr,
   input  logic [NAX-1:0][DW-1:0]   wdata,
   input  logic [AW-1:0]            raddr,
   output logic [DW-1:0]            rdata
);

   logic [DW-1:0] mem [DEPTH];

   if (MEM_RESET) begin : g_rst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
         end else begin
            for (int p = 0; p < int'(NAX); p++) begin
               if (we[p]) mem[waddr[p]] <= wdata[p];
            end
         end
      end
   end else begin : g_norst
      always_ff @(posedge clk) begin
         for (int p = 0; p < int'(NAX); p++) begin
            if (we[p]) mem[waddr[p]] <= wdata[p];
         end
      end
   end

   assign rdata = mem[raddr];

   for (genvar p = 0; p < NAX; p++) begin : g_port_chk
      // R1: every write lands inside the pool
      p_waddr_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
         we[p] |-> (waddr[p] < AW'(DEPTH)));
   end

endmodule

// File: rtl/asr_ctrl.sv
module asr_ctrl
   import asr_pkg::*;
#(
   parameter int unsigned DEPTH = 192,
   parameter int unsigned AW    = 8,
   parameter int unsigned CW    = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    buf_en,
   input  logic [NAX-1:0]          axis_en,
   input  logic                    byte_mode,
   input  logic                    keep,
   input  logic                    pop,
   input  logic                    cnt_rd,
   output logic                    do_wr,
   output logic [NAX-1:0][AW-1:0]  waddr,
   output logic [AW-1:0]           rd_ptr,
   output logic                    rd_half,
   output logic                    empty,
   output logic [CW-1:0]           fill,
   output logic [CW-1:0]           fill_cnt,
   output logic                    ovf,
   output logic                    flush
);

   localparam logic [AW:0] DEPTH_A = (AW+1)'(DEPTH);
   localparam logic [CW:0] DEPTH_C = (CW+1)'(DEPTH);
   localparam int unsigned CFGW    = NAX + 2;

   function automatic logic [AW-1:0] wrap(input logic [AW:0] s);
      return (s >= DEPTH_A) ? AW'(s - DEPTH_A) : AW'(s);
   endfunction

   logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
   logic [CW-1:0]   fill_q, cnt_q, fill_mid;
   logic            half_q, ovf_q;
   logic [CFGW-1:0] cfg_q, cfg_now;
   logic [1:0]      n_ax;
   logic            pop_ok, ent_pop, drop;

   assign n_ax     = axis_count(axis_en);
   assign cfg_now  = {buf_en, axis_en, byte_mode};
   assign flush    = (cfg_now != cfg_q);
   assign do_wr    = keep && !flush && (n_ax != 2'd0);
   assign empty    = (fill_q == '0);
   assign pop_ok   = pop && !empty && !flush;
   assign ent_pop  = pop_ok && (byte_mode || half_q);
   assign fill_mid = fill_q - CW'(ent_pop);
   assign drop     = do_wr && (({1'b0, fill_mid} + (CW+1)'(n_ax)) > DEPTH_C);

   for (genvar p = 0; p < NAX; p++) begin : g_waddr
      assign waddr[p] = wrap({1'b0, wr_ptr_q} + (AW+1)'(p));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         fill_q   <= '0;
         cnt_q    <= '0;
         half_q   <= 1'b0;
         ovf_q    <= 1'b0;
         cfg_q    <= '0;
      end else begin
         cfg_q <= cfg_now;
         if (cnt_rd) cnt_q <= fill_q;
         if (drop)        ovf_q <= 1'b1;
         else if (cnt_rd) ovf_q <= 1'b0;
         if (flush) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            fill_q   <= '0;
            half_q   <= 1'b0;
         end else begin
            if (do_wr) wr_ptr_q <= wrap({1'b0, wr_ptr_q} + (AW+1)'(n_ax));
            rd_ptr_q <= wrap({1'b0, rd_ptr_q} + (AW+1)'(ent_pop)
                             + (drop ? (AW+1)'(n_ax) : '0));
            fill_q   <= (drop || !do_wr) ? fill_mid : fill_mid + CW'(n_ax);
            half_q   <= (drop || ent_pop) ? 1'b0 : (pop_ok ? 1'b1 : half_q);
         end
      end
   end

   assign rd_ptr   = rd_ptr_q;
   assign rd_half  = half_q;
   assign fill     = fill_q;
   assign fill_cnt = cnt_q;
   assign ovf      = ovf_q;

   // R1: the fill level never passes the pool size
   p_fill_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= CW'(DEPTH));
   // R3: a disabled store is empty after the next edge
   p_off_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !buf_en |=> (fill_q == '0));
   // R8: the count register holds the level seen at the access
   p_cnt_snap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rd |=> (cnt_q == $past(fill_q)));
   // R9: an overwrite leaves the flag set
   p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      drop |=> ovf_q);
   // R9: a count access without a new overwrite clears the flag
   p_ovf_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_rd && !drop) |=> !ovf_q);
   // R10: a configuration change leaves nothing stored
   p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (fill_q == '0 && !half_q));
   // R11: popping an empty store moves nothing
   p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !do_wr && !flush) |=> ($stable(rd_ptr_q) && fill_q == '0));

endmodule

// File: rtl/asr_fmt.sv
module asr_fmt #(
   parameter int unsigned DW = 11
) (
   input  logic [DW-1:0] entry,
   input  logic          half,
   input  logic          byte_mode,
   input  logic          empty,
   output logic [7:0]    out_byte
);

   logic [7:0] hi_byte;

   if (DW == 16) begin : g_full_hi
      assign hi_byte = entry[15:8];
   end else begin : g_ext_hi
      assign hi_byte = {{(16-DW){entry[DW-1]}}, entry[DW-1:8]};
   end

   always_comb begin
      if (empty)          out_byte = '0;
      else if (byte_mode) out_byte = entry[DW-1 -: 8];
      else if (!half)     out_byte = hi_byte;
      else                out_byte = entry[7:0];
   end

endmodule

// File: rtl/axis_sample_ring.sv
module axis_sample_ring
   import asr_pkg::*;
#(
   parameter int unsigned DW        = 11,
   parameter int unsigned DEPTH     = 192,
   parameter bit          MEM_RESET = 1'b1,
   parameter int unsigned AW        = $clog2(DEPTH),
   parameter int unsigned CW        = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_stb,
   input  logic [DW-1:0] smp_x,
   input  logic [DW-1:0] smp_y,
   input  logic [DW-1:0] smp_z,
   input  logic          cfg_buf_en,
   input  logic [2:0]    cfg_axis_en,
   input  logic          cfg_byte_mode,
   input  logic [1:0]    cfg_rate_sel,
   input  logic          cfg_irq_en,
   input  logic          cfg_irq_hi,
   input  logic          rd_pop,
   input  logic          cnt_rd,
   output logic [7:0]    rd_byte,
   output logic [CW-1:0] fill_cnt,
   output logic          irq,
   output logic          ovf
);

   if (DW < 9 || DW > 16) begin : g_bad_dw
      $error("axis_sample_ring: DW must lie in 9..16");
   end
   if (DEPTH < 12 || (DEPTH % 12) != 0) begin : g_bad_depth
      $error("axis_sample_ring: DEPTH must be a nonzero multiple of 12");
   end

   localparam logic [CW-1:0] THR_LO = CW'(DEPTH / 2);
   localparam logic [CW-1:0] THR_HI = CW'((DEPTH * 3) / 4);

   logic                   keep, do_wr, flush, rd_half, empty;
   logic [NAX-1:0][AW-1:0] waddr;
   logic [NAX-1:0][DW-1:0] ax_val, port_dat;
   logic [NAX-1:0]         port_we;
   logic [AW-1:0]          rd_ptr;
   logic [CW-1:0]          fill;
   logic [DW-1:0]          rd_entry;
   logic [1:0]             wr_slot;

   assign ax_val = {smp_z, smp_y, smp_x};

   asr_decim #(.PW(2)) u_decim (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (flush),
      .stb      (smp_stb && cfg_buf_en),
      .rate_sel (cfg_rate_sel),
      .keep     (keep)
   );

   asr_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .buf_en    (cfg_buf_en),
      .axis_en   (cfg_axis_en),
      .byte_mode (cfg_byte_mode),
      .keep      (keep),
      .pop       (rd_pop),
      .cnt_rd    (cnt_rd),
      .do_wr     (do_wr),
      .waddr     (waddr),
      .rd_ptr    (rd_ptr),
      .rd_half   (rd_half),
      .empty     (empty),
      .fill      (fill),
      .fill_cnt  (fill_cnt),
      .ovf       (ovf),
      .flush     (flush)
   );

   // pack enabled axes onto consecutive write ports in X, Y, Z order
   always_comb begin
      port_we  = '0;
      port_dat = '0;
      wr_slot  = 2'd0;
      for (int a = 0; a < int'(NAX); a++) begin
         if (cfg_axis_en[a]) begin
            port_we[wr_slot]  = do_wr;
            port_dat[wr_slot] = ax_val[a];
            wr_slot           = wr_slot + 2'd1;
         end
      end
   end

   asr_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .MEM_RESET(MEM_RESET)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (port_we),
      .waddr (waddr),
      .wdata (port_dat),
      .raddr (rd_ptr),
      .rdata (rd_entry)
   );

   asr_fmt #(.DW(DW)) u_fmt (
      .entry     (rd_entry),
      .half      (rd_half),
      .byte_mode (cfg_byte_mode),
      .empty     (empty),
      .out_byte  (rd_byte)
   );

   assign irq = cfg_irq_en && (fill != '0) && (fill >= (cfg_irq_hi ? THR_HI : THR_LO));

   // R7: the interrupt only stands above the lower threshold
   p_irq_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (fill >= THR_LO));
   // R2: a write never uses more ports than axes enabled
   p_port_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(port_we) <= $countones(cfg_axis_en));

endmodule

// File: tb/axis_sample_ring_tb.sv
module axis_sample_ring_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [10:0] smp_x = '0, smp_y = '0, smp_z = '0;
   logic        cfg_buf_en = 1'b0;
   logic [2:0]  cfg_axis_en = '0;
   logic        cfg_byte_mode = 1'b0;
   logic [1:0]  cfg_rate_sel = '0;
   logic        cfg_irq_en = 1'b0;
   logic        cfg_irq_hi = 1'b0;
   logic        rd_pop = 1'b0;
   logic        cnt_rd = 1'b0;
   logic [7:0]  rd_byte;
   logic [7:0]  fill_cnt;
   logic        irq, ovf;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   axis_sample_ring u_dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
      .smp_x(smp_x), .smp_y(smp_y), .smp_z(smp_z),
      .cfg_buf_en(cfg_buf_en), .cfg_axis_en(cfg_axis_en),
      .cfg_byte_mode(cfg_byte_mode), .cfg_rate_sel(cfg_rate_sel),
      .cfg_irq_en(cfg_irq_en), .cfg_irq_hi(cfg_irq_hi),
      .rd_pop(rd_pop), .cnt_rd(cnt_rd),
      .rd_byte(rd_byte), .fill_cnt(fill_cnt), .irq(irq), .ovf(ovf)
   );

   function automatic logic [7:0] hi11(input logic [10:0] v);
      return {{5{v[10]}}, v[10:8]};
   endfunction
   function automatic logic [7:0] b8(input logic [10:0] v);
      return v[10:3];
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic push(input logic [10:0] x, input logic [10:0] y, input logic [10:0] z);
      smp_stb = 1'b1; smp_x = x; smp_y = y; smp_z = z;
      tick();
      smp_stb = 1'b0;
   endtask

   task automatic pop_byte(output logic [7:0] b);
      b = rd_byte;
      rd_pop = 1'b1;
      tick();
      rd_pop = 1'b0;
   endtask

   task automatic get_cnt(output int c);
      cnt_rd = 1'b1;
      tick();
      cnt_rd = 1'b0;
      c = int'(fill_cnt);
   endtask

   task automatic set_cfg(input logic en, input logic [2:0] ax, input logic bm, input logic [1:0] rs);
      cfg_buf_en = en; cfg_axis_en = ax; cfg_byte_mode = bm; cfg_rate_sel = rs;
      tick();
      tick();
   endtask

   task automatic t_reset();
      chk("R11 reset byte", int'(rd_byte), 0);
      chk("R8 reset count", int'(fill_cnt), 0);
      chk("R7 reset irq", int'(irq), 0);
      chk("R9 reset ovf", int'(ovf), 0);
   endtask

   task automatic t_wide_all();
      logic [10:0] xs[3], ys[3], zs[3];
      logic [7:0]  b;
      int c;
      xs = '{11'h5A3, 11'h001, 11'h3C7};
      ys = '{11'h0F1, 11'h7FF, 11'h455};
      zs = '{11'h2C4, 11'h400, 11'h09E};
      set_cfg(1'b1, 3'b111, 1'b0, 2'd0);
      push(xs[0], ys[0], zs[0]);
      push(xs[1], ys[1], zs[1]);
      get_cnt(c);
      chk("R8 count after two samples", c, 6);
      push(xs[2], ys[2], zs[2]);
      chk("R8 count holds without access", int'(fill_cnt), 6);
      get_cnt(c);
      chk("R8 count refreshed", c, 9);
      for (int s = 0; s < 3; s++) begin
         pop_byte(b); chk("R5 X high byte", int'(b), int'(hi11(xs[s])));
         pop_byte(b); chk("R5 X low byte", int'(b), int'(xs[s][7:0]));
         pop_byte(b); chk("R2 Y high byte", int'(b), int'(hi11(ys[s])));
         pop_byte(b); chk("R5 Y low byte", int'(b), int'(ys[s][7:0]));
         pop_byte(b); chk("R2 Z high byte", int'(b), int'(hi11(zs[s])));
         pop_byte(b); chk("R5 Z low byte", int'(b), int'(zs[s][7:0]));
      end
      pop_byte(b);
      chk("R11 empty pop byte", int'(b), 0);
      get_cnt(c);
      chk("R11 empty pop count", c, 0);
      push(11'h6AB, 11'h155, 11'h0CC);
      pop_byte(b);
      chk("R11 pointer intact after empty pop", int'(b), int'(hi11(11'h6AB)));
   endtask

   task automatic t_narrow_yz();
      logic [7:0] b;
      int c;
      push(11'h111, 11'h222, 11'h333);
      set_cfg(1'b1, 3'b110, 1'b1, 2'd0);
      get_cnt(c);
      chk("R10 flush on config change", c, 0);
      chk("R10 byte after flush", int'(rd_byte), 0);
      for (int i = 0; i < 3; i++) push(11'(i * 9), 11'h7A5 - 11'(i * 37), 11'h0F8 + 11'(i * 53));
      get_cnt(c);
      chk("R2 entries for two axes", c, 6);
      for (int i = 0; i < 3; i++) begin
         pop_byte(b); chk("R6 Y narrow byte", int'(b), int'(b8(11'h7A5 - 11'(i * 37))));
         pop_byte(b); chk("R2 Z follows Y", int'(b), int'(b8(11'h0F8 + 11'(i * 53))));
      end
      chk("R11 empty after narrow read", int'(rd_byte), 0);
   endtask

   task automatic t_disabled();
      int c;
      set_cfg(1'b0, 3'b111, 1'b1, 2'd0);
      for (int i = 0; i < 4; i++) push(11'h7F0, 11'h7F0, 11'h7F0);
      get_cnt(c);
      chk("R3 nothing stored while off", c, 0);
      chk("R3 byte while off", int'(rd_byte), 0);
   endtask

   task automatic t_divider();
      logic [7:0] b;
      int c;
      set_cfg(1'b1, 3'b001, 1'b1, 2'd1);
      for (int i = 0; i < 8; i++) push(11'(i << 3), 11'h0, 11'h0);
      get_cnt(c);
      chk("R4 divide by two count", c, 4);
      for (int i = 0; i < 4; i++) begin
         pop_byte(b); chk("R4 every second sample", int'(b), 2 * i);
      end
      cfg_rate_sel = 2'd2;
      tick();
      for (int i = 0; i < 8; i++) push(11'(i << 3), 11'h0, 11'h0);
      get_cnt(c);
      chk("R4 divide by four count, no flush", c, 2);
      pop_byte(b); chk("R4 quarter first", int'(b), 0);
      pop_byte(b); chk("R4 quarter second", int'(b), 4);
   endtask

   task automatic t_irq_single_axis();
      logic [7:0] b;
      int c;
      int k = 0;
      cfg_irq_en = 1'b1;
      cfg_irq_hi = 1'b0;
      set_cfg(1'b1, 3'b100, 1'b1, 2'd0);
      repeat (95) begin push(11'h0, 11'h0, 11'((k & 255) << 3)); k++; end
      chk("R7 below half", int'(irq), 0);
      push(11'h0, 11'h0, 11'((k & 255) << 3)); k++;
      chk("R7 at half", int'(irq), 1);
      cfg_irq_hi = 1'b1;
      tick();
      chk("R7 high threshold not reached", int'(irq), 0);
      repeat (47) begin push(11'h0, 11'h0, 11'((k & 255) << 3)); k++; end
      chk("R7 just below three quarters", int'(irq), 0);
      push(11'h0, 11'h0, 11'((k & 255) << 3)); k++;
      chk("R7 at three quarters", int'(irq), 1);
      cfg_irq_en = 1'b0;
      tick();
      chk("R7 masked", int'(irq), 0);
      repeat (48) begin push(11'h0, 11'h0, 11'((k & 255) << 3)); k++; end
      chk("R9 no overflow when exactly full", int'(ovf), 0);
      push(11'h0, 11'h0, 11'((k & 255) << 3)); k++;
      chk("R9 overflow set", int'(ovf), 1);
      get_cnt(c);
      chk("R1 single axis holds 192", c, 192);
      chk("R9 overflow cleared by count read", int'(ovf), 0);
      pop_byte(b);
      chk("R1 oldest dropped", int'(b), 1);
   endtask

   task automatic t_full_three_axis();
      logic [7:0] b;
      int c;
      set_cfg(1'b1, 3'b111, 1'b1, 2'd0);
      for (int i = 0; i < 64; i++) push(11'(i << 3), 11'h7F8, 11'h400);
      chk("R1 64 samples fit", int'(ovf), 0);
      push(11'(64 << 3), 11'h7F8, 11'h400);
      chk("R9 65th sample overflows", int'(ovf), 1);
      get_cnt(c);
      chk("R1 three axis count stays at pool size", c, 192);
      pop_byte(b);
      chk("R1 first byte is second sample X", int'(b), 1);
      pop_byte(b);
      chk("R2 Y follows X after drop", int'(b), 8'hFF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_wide_all();
      t_narrow_yz();
      t_disabled();
      t_divider();
      t_irq_single_axis();
      t_full_three_axis();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule